// File: doc/BRIEF.md
# Configurable Interrupt Source Capture Bank

This block turns a wide set of asynchronous interrupt request lines into clean, latched status bits. Each line passes through a synchroniser. A per-source detector then watches the line for one of four conditions: a rising edge, a falling edge, a high level or a low level. When the chosen condition occurs, the source's status bit is set. A per-source enable bit gates that status onto the `pending` output vector. A later stage can use `pending` to arbitrate among sources and to raise host requests.

Software reaches the block through a single-cycle register write port and a combinational read port. Detection modes, status bits and enable bits can be changed a whole 32-bit word at a time. Status clears and enable changes can also be made one source at a time, by writing a source number to an index register. The address is `{region[2:0], word[2:0]}`. Source n sits in word n/32 at bit n%32 of every per-source word register.

Top module: `isc_capture`

## Requirements
- R1: While the reset is asserted, status and enable bits read 0 and `pending` is 0. Every polarity bit and every type bit reads 1, which is the rising-edge mode.
- R2: Region 0 holds the polarity words (1 = rising or high, 0 = falling or low) and region 1 holds the type words (1 = edge, 0 = level). Both regions are read/write. The word select is the low three address bits, and source n is word n/32, bit n%32.
- R3: An edge-type source with polarity 1 sets its status bit on a 0-to-1 change of its input. The bit is set at most three clock edges after the input changes, and it stays set after the input returns low.
- R4: An edge-type source with polarity 0 sets its status bit only on a 1-to-0 change of its input. A rising change leaves its status unchanged.
- R5: A level-type source with polarity 1 sets its status bit while its input is high. The bit stays set until it is cleared after the input has gone low.
- R6: A level-type source with polarity 0 sets its status bit while its input is low. A clear written while the input is still low leaves the bit reading 1.
- R7: A status bit latches regardless of its enable bit. `pending` is the bitwise AND of status and enable.
- R8: Writing to region 2 (the status word) clears each status bit whose write-data bit is 1 and leaves the others unchanged. Reading region 2 returns the status word.
- R9: Writing source number k to address 0x28 clears only status bit k.
- R10: In region 3, each 1 in the write data sets the matching enable bit. In region 4, each 1 clears the matching enable bit. Only the addressed word changes, and both regions read back the enable word.
- R11: Writing k to 0x29 sets only enable bit k, and writing k to 0x2A clears only enable bit k. A value of NUM_SRC or more has no effect.
- R12: When a clear and a new detection fall on the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 6 | Register address `{region, word}` for reads and writes |
| wdata | input | 32 | Write data or source index |
| rdata | output | 32 | Combinational read data for `addr` |
| src_in | input | NUM_SRC | Asynchronous interrupt request lines |
| pending | output | NUM_SRC | Status AND enable per source |

## Verification
Several properties are checked on every cycle:
- a status bit is never lost unless a clear hit it;
- an active level always produces a set status bit on the next cycle, whether or not a clear was written;
- `pending` never shows a source that is not both latched and enabled;
- index enable writes land on exactly the named bit;
- word writes to the polarity region read back.

Some behaviour depends on a particular history of the inputs and can only be shown by the bench scenarios. These include the direction each edge mode responds to, the lack of effect of out-of-range indices, how far a word write reaches, a clear and an edge landing on the same cycle, and the full reset state.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int WORD_W   = 32;
  localparam int REGION_W = 3;
  localparam int WSEL_W   = 3;
  localparam int ADDR_W   = REGION_W + WSEL_W;

  typedef enum logic [REGION_W-1:0] {
    RGN_POL   = 3'd0,
    RGN_TYP   = 3'd1,
    RGN_STAT  = 3'd2,
    RGN_ENSET = 3'd3,
    RGN_ENCLR = 3'd4,
    RGN_INDEX = 3'd5,
    RGN_PEND  = 3'd6,
    RGN_NONE  = 3'd7
  } region_e;

  // word selects inside the index region
  localparam logic [WSEL_W-1:0] IDX_STAT_CLR = 3'd0;
  localparam logic [WSEL_W-1:0] IDX_EN_SET   = 3'd1;
  localparam logic [WSEL_W-1:0] IDX_EN_CLR   = 3'd2;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/isc_detect.sv
module isc_detect #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic [NUM_SRC-1:0] prev_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] typ_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o
);
  logic [NUM_SRC-1:0] set_v;
  logic [NUM_SRC-1:0] stat_d, stat_q;
  logic               stat_we;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic rise_w, fall_w, edge_w, level_w;
    assign rise_w   = sync_i[n] & ~prev_i[n];
    assign fall_w   = ~sync_i[n] & prev_i[n];
    assign edge_w   = pol_i[n] ? rise_w : fall_w;
    assign level_w  = ~(sync_i[n] ^ pol_i[n]);
    assign set_v[n] = typ_i[n] ? edge_w : level_w;
  end

  // a detection in the same cycle as a clear wins
  always_comb begin
    stat_d  = set_v | (stat_q & ~clr_i);
    stat_we = |(set_v | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_we) stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/isc_regs.sv
module isc_regs import isc_pkg::*; #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] pending_i,
  output logic [NUM_SRC-1:0] pol_o,
  output logic [NUM_SRC-1:0] typ_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [WORD_W-1:0]  rdata
);
  localparam int NUM_WORDS = NUM_SRC / WORD_W;
  localparam int IDX_W     = $clog2(NUM_SRC);

  region_e            rgn;
  logic [WSEL_W-1:0]  wsel;
  logic               idx_ok;
  logic [NUM_SRC-1:0] one_v, idx_hot;
  logic [NUM_SRC-1:0] pol_d, pol_q, typ_d, typ_q, en_d, en_q;
  logic               pol_we, typ_we, en_we;

  assign rgn     = region_e'(addr[ADDR_W-1:WSEL_W]);
  assign wsel    = addr[WSEL_W-1:0];
  assign idx_ok  = wdata < WORD_W'(NUM_SRC);
  assign one_v   = {{(NUM_SRC-1){1'b0}}, 1'b1};
  assign idx_hot = idx_ok ? (one_v << wdata[IDX_W-1:0]) : '0;

  always_comb begin
    pol_d = pol_q;
    typ_d = typ_q;
    en_d  = en_q;
    clr_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wr_en && wsel == WSEL_W'(w)) begin
        unique case (rgn)
          RGN_POL:   pol_d[w*WORD_W +: WORD_W] = wdata;
          RGN_TYP:   typ_d[w*WORD_W +: WORD_W] = wdata;
          RGN_STAT:  clr_o[w*WORD_W +: WORD_W] = wdata;
          RGN_ENSET: en_d[w*WORD_W +: WORD_W]  = en_q[w*WORD_W +: WORD_W] | wdata;
          RGN_ENCLR: en_d[w*WORD_W +: WORD_W]  = en_q[w*WORD_W +: WORD_W] & ~wdata;
          default: ;
        endcase
      end
    end
    if (wr_en && rgn == RGN_INDEX) begin
      unique case (wsel)
        IDX_STAT_CLR: clr_o = clr_o | idx_hot;
        IDX_EN_SET:   en_d  = en_d | idx_hot;
        IDX_EN_CLR:   en_d  = en_d & ~idx_hot;
        default: ;
      endcase
    end
  end

  assign pol_we = wr_en && rgn == RGN_POL;
  assign typ_we = wr_en && rgn == RGN_TYP;
  assign en_we  = wr_en && (rgn == RGN_ENSET || rgn == RGN_ENCLR || rgn == RGN_INDEX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '1;
      typ_q <= '1;
      en_q  <= '0;
    end else begin
      if (pol_we) pol_q <= pol_d;
      if (typ_we) typ_q <= typ_d;
      if (en_we)  en_q  <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wsel == WSEL_W'(w)) begin
        unique case (rgn)
          RGN_POL:              rdata = pol_q[w*WORD_W +: WORD_W];
          RGN_TYP:              rdata = typ_q[w*WORD_W +: WORD_W];
          RGN_STAT:             rdata = stat_i[w*WORD_W +: WORD_W];
          RGN_ENSET, RGN_ENCLR: rdata = en_q[w*WORD_W +: WORD_W];
          RGN_PEND:             rdata = pending_i[w*WORD_W +: WORD_W];
          default: ;
        endcase
      end
    end
  end

  assign pol_o = pol_q;
  assign typ_o = typ_q;
  assign en_o  = en_q;
endmodule

// File: rtl/isc_capture.sv
module isc_capture import isc_pkg::*; #(
  parameter int NUM_SRC     = 64,  // multiple of 32, at most 256
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] pending
);
  logic [1:0]         rst_sync_q;
  logic               rst_ni;
  logic [NUM_SRC-1:0] sync_v, prev_v, pol_v, typ_v, en_v, clr_v, stat_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  isc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .async_i(src_in), .sync_o(sync_v), .prev_o(prev_v)
  );

  isc_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk(clk), .rst_n(rst_ni), .sync_i(sync_v), .prev_i(prev_v),
    .pol_i(pol_v), .typ_i(typ_v), .clr_i(clr_v), .stat_o(stat_v)
  );

  isc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stat_i(stat_v), .pending_i(pending), .pol_o(pol_v), .typ_o(typ_v),
    .en_o(en_v), .clr_o(clr_v), .rdata(rdata)
  );

  assign pending = stat_v & en_v;
endmodule

// File: rtl/isc_capture_chk.sv
module isc_capture_chk import isc_pkg::*; #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [WORD_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] sync_v,
  input logic [NUM_SRC-1:0] pol_v,
  input logic [NUM_SRC-1:0] typ_v,
  input logic [NUM_SRC-1:0] en_v,
  input logic [NUM_SRC-1:0] clr_v,
  input logic [NUM_SRC-1:0] stat_v,
  input logic [NUM_SRC-1:0] pending
);
  localparam int NUM_WORDS = NUM_SRC / WORD_W;
  localparam int IDX_W     = $clog2(NUM_SRC);

  // R1
  always @(posedge clk) begin
    if (!rst_ni) begin
      reset_state_chk: assert (stat_v == '0 && en_v == '0 && pending == '0);
    end
  end

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_v) & ~$past(clr_v)) & ~stat_v) == '0));

  // R6
  level_sets_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (((~$past(typ_v)) & ~($past(sync_v) ^ $past(pol_v)) & ~stat_v) == '0));

  // R7
  pending_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pending & ~(stat_v & en_v)) == '0);

  // R11
  idx_en_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr == {RGN_INDEX, IDX_EN_SET} && wdata < WORD_W'(NUM_SRC))
    |=> en_v[$past(wdata[IDX_W-1:0])]);

  // R11
  idx_en_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr == {RGN_INDEX, IDX_EN_CLR} && wdata < WORD_W'(NUM_SRC))
    |=> !en_v[$past(wdata[IDX_W-1:0])]);

  // R2
  pol_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && addr[ADDR_W-1:WSEL_W] == RGN_POL && int'(addr[WSEL_W-1:0]) < NUM_WORDS)
    |=> pol_v[$past(addr[WSEL_W-1:0])*WORD_W +: WORD_W] == $past(wdata));
endmodule

bind isc_capture isc_capture_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sync_v(sync_v), .pol_v(pol_v), .typ_v(typ_v), .en_v(en_v),
  .clr_v(clr_v), .stat_v(stat_v), .pending(pending)
);

// File: tb/isc_capture_test.sv
module isc_capture_test;
  localparam int NSRC = 64;
  localparam logic [1:0] OP_WR = 2'd0, OP_SRC = 2'd1, OP_RD = 2'd2, OP_PND = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [5:0]  addr;
    logic [63:0] data;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  4'd1,  6'h00, 64'hFFFF_FFFF},          // R1 polarity reset
    '{OP_RD,  4'd1,  6'h09, 64'hFFFF_FFFF},          // R1 type reset
    '{OP_RD,  4'd1,  6'h10, 64'h0},                  // R1 status reset
    '{OP_RD,  4'd1,  6'h19, 64'h0},                  // R1 enable reset
    '{OP_PND, 4'd1,  6'h00, 64'h0},                  // R1 pending reset
    '{OP_WR,  4'd2,  6'h00, 64'hFFFF_FFF5},          // R2 src1,src3 polarity 0
    '{OP_WR,  4'd2,  6'h08, 64'hFFFF_FFF3},          // R2 src2,src3 level
    '{OP_WR,  4'd2,  6'h01, 64'hFFFF_FEFF},          // R2 src40 falling
    '{OP_RD,  4'd2,  6'h00, 64'hFFFF_FFF5},          // R2
    '{OP_RD,  4'd2,  6'h01, 64'hFFFF_FEFF},          // R2
    '{OP_RD,  4'd2,  6'h08, 64'hFFFF_FFF3},          // R2
    '{OP_RD,  4'd6,  6'h10, 64'h8},                  // R6 low level latched
    '{OP_WR,  4'd6,  6'h10, 64'h8},                  // R6 clear while low
    '{OP_RD,  4'd6,  6'h10, 64'h8},                  // R6 still set
    '{OP_SRC, 4'd3,  6'h00, 64'h0000_0100_0000_000F},// R3 raise src0..3,40
    '{OP_RD,  4'd3,  6'h10, 64'hD},                  // R3 R5 src0,src2 set
    '{OP_RD,  4'd4,  6'h11, 64'h0},                  // R4 rise ignored
    '{OP_PND, 4'd7,  6'h00, 64'h0},                  // R7 nothing enabled
    '{OP_SRC, 4'd4,  6'h00, 64'h0},                  // R4 drop all
    '{OP_RD,  4'd4,  6'h10, 64'hF},                  // R4 src1 fell
    '{OP_RD,  4'd4,  6'h11, 64'h100},                // R4 src40 fell
    '{OP_WR,  4'd10, 6'h18, 64'h5},                  // R10 set en 0,2
    '{OP_WR,  4'd10, 6'h19, 64'h100},                // R10 set en 40
    '{OP_RD,  4'd10, 6'h18, 64'h5},                  // R10
    '{OP_PND, 4'd7,  6'h00, 64'h0000_0100_0000_0005},// R7
    '{OP_WR,  4'd10, 6'h20, 64'hFFFF_FFFF},          // R10 clear word 0
    '{OP_RD,  4'd10, 6'h20, 64'h0},                  // R10
    '{OP_RD,  4'd10, 6'h19, 64'h100},                // R10 word 1 untouched
    '{OP_PND, 4'd10, 6'h00, 64'h0000_0100_0000_0000},// R10
    '{OP_WR,  4'd11, 6'h29, 64'd1},                  // R11 enable src1
    '{OP_WR,  4'd11, 6'h29, 64'd64},                 // R11 out of range
    '{OP_WR,  4'd11, 6'h2A, 64'd40},                 // R11 disable src40
    '{OP_RD,  4'd11, 6'h18, 64'h2},                  // R11
    '{OP_RD,  4'd11, 6'h19, 64'h0},                  // R11
    '{OP_PND, 4'd11, 6'h00, 64'h2},                  // R11
    '{OP_WR,  4'd9,  6'h28, 64'd1},                  // R9 clear src1
    '{OP_RD,  4'd9,  6'h10, 64'hD},                  // R9 others kept
    '{OP_PND, 4'd9,  6'h00, 64'h0},                  // R9
    '{OP_WR,  4'd8,  6'h11, 64'hFFFF_FFFF},          // R8 clear word 1
    '{OP_RD,  4'd8,  6'h11, 64'h0},                  // R8
    '{OP_WR,  4'd8,  6'h10, 64'h5},                  // R8 clear src0,src2
    '{OP_RD,  4'd8,  6'h10, 64'h8}                   // R8 R5 src2 cleared
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b1;
  logic            wr_en = 1'b0;
  logic [5:0]      addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NSRC-1:0] src_in = '0;
  logic [NSRC-1:0] pending;
  int              checks = 0;
  int              errors = 0;
  bit              done = 1'b0;

  always #10 clk = ~clk;  // 20-unit period, 50 MHz at 1 ns

  isc_capture #(.NUM_SRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .pending(pending)
  );

  task automatic do_write(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_rd(input logic [5:0] a, input logic [31:0] exp, input int req);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic check_pnd(input logic [63:0] exp, input int req);
    #1;
    checks++;
    if (pending !== exp) begin
      errors++;
      $display("FAIL R%0d pending actual=%h expected=%h", req, pending, exp);
    end
    @(negedge clk);
  endtask

  task automatic drive_src(input logic [63:0] v);
    src_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   do_write(VECS[i].addr, VECS[i].data[31:0]);
        OP_SRC:  drive_src(VECS[i].data);
        OP_RD:   check_rd(VECS[i].addr, VECS[i].data[31:0], int'(VECS[i].req));
        default: check_pnd(VECS[i].data, int'(VECS[i].req));
      endcase
    end

    // R12: clear of src0 lands on the same edge as its rising detection
    src_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    do_write(6'h10, 32'h1);
    check_rd(6'h10, 32'h9, 12);  // R12

    // R1: mid-run reset restores defaults
    src_in = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_rd(6'h00, 32'hFFFF_FFFF, 1);  // R1
    check_rd(6'h08, 32'hFFFF_FFFF, 1);  // R1
    check_rd(6'h10, 32'h0, 1);          // R1
    check_rd(6'h18, 32'h0, 1);          // R1
    check_pnd(64'h0, 1);                // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R7: default rising mode after reset, enabled by index
    do_write(6'h29, 32'd5);
    drive_src(64'h20);
    check_pnd(64'h20, 3);  // R3

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before all requirement checks ran");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule